// File: doc/BRIEF.md
# Four-Way Instruction Translation Buffer with Pairwise-Order Replacement

The block is a small, fully associative translation buffer for instruction fetch. It holds four translations, each with its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag and a shared flag. A fetch address is compared with all four entries in parallel. One cycle later the block reports one of three outcomes: a single hit (with the way index and the translated physical address), a multiple hit, or a miss.

Recency is kept in a six-bit replacement field. Each bit records the relative age of one pair of ways. A hit rewrites the bits that involve the hit way. A miss selects a victim way from the replacement field and raises a refill request toward an external, larger translation buffer. The block then waits in a refill state until the new entry arrives, and writes that entry into the victim way. The requester retries the fetch once the block is back in the lookup state. The replacement field can also be loaded from outside, as a control register would be.

The controller has two states. S_LOOKUP accepts fetches. S_REFILL holds the refill request and ignores fetches. The transitions are:
- LOOKUP_TO_REFILL: taken on a miss that has a valid victim.
- REFILL_TO_LOOKUP: taken when the fill arrives.
- LOOKUP_STAY: taken on a hit, a multiple hit, a miss with no decodable victim, or an idle cycle.
- REFILL_STAY: taken while no fill is present.

Top module: `itlb4_plru`

## Requirements
- R1: After reset, all four ways are invalid, `lru_state` is 000000, and `rsp_valid` and `refill_req` are 0. The first lookup therefore misses.
- R2: A way matches when all three conditions hold:
  - the way is valid;
  - its address-space check passes;
  - the fetch address, with the in-page offset bits cleared, equals the way's page number shifted left by 10 with the same bits cleared.
  The in-page offset is 10, 12, 16 or 20 bits for size codes 0, 1, 2 and 3. An address one byte outside the page misses.
- R3: The stored tag must equal `cur_asid`, except in two cases. The check is skipped when the way's shared flag is 1. It is also skipped when both `single_vspace` and `priv_mode` are 1.
- R4: On a single hit, `rsp_paddr` is formed in two parts. The upper part is the way's frame number shifted left by 10, with the in-page offset bits cleared. The offset bits are taken from the fetch address.
- R5: When more than one way matches, the block reports `rsp_multi` instead of a hit. In that case `lru_state` does not change and no refill is requested.
- R6: `lru_state[5:0]` stands for replacement bits 31 down to 26. A hit updates it as follows:
  - way 0 clears [5:3];
  - way 1 sets [5] and clears [2:1];
  - way 2 sets [4] and [2] and clears [0];
  - way 3 sets [3], [1] and [0].
- R7: The victim is the first way, in order 0, 1, 2, 3, whose pattern fits `lru_state`:
  - way 0: [5:3] all 1;
  - way 1: [5]=0 and [2:1] both 1;
  - way 2: [4]=0, [2]=0 and [0]=1;
  - way 3: [3], [1] and [0] all 0.
- R8: A miss with a victim raises `refill_req`, with `refill_vaddr` equal to the fetch address, in the same cycle as the miss response. The request holds until `fill_valid` is seen. While the block waits, fetches give no response and leave `lru_state` unchanged.
- R9: A fill writes the fill fields as a valid entry into the victim chosen at the miss. It applies the R6 update for that way, drops `refill_req` and returns to lookup.
- R10: A miss when `lru_state` fits no victim pattern reports `rsp_miss` with `rsp_lru_err`, and raises no refill.
- R11: `lru_load` writes `lru_load_val` into `lru_state` on the next edge. It overrides a hit update in the same cycle.
- R12: Every accepted lookup gives exactly one outcome (hit, miss or multiple hit) with `rsp_valid` high for exactly one cycle, one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Fetch lookup request |
| lookup_vaddr | input | VA_W | Fetch virtual address |
| cur_asid | input | ASID_W | Current address-space tag |
| priv_mode | input | 1 | Core is in privileged mode |
| single_vspace | input | 1 | Single-virtual-space mode enable |
| lru_load | input | 1 | Load replacement field |
| lru_load_val | input | 6 | Value for replacement field |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VA_W-10 | Refill virtual page number |
| fill_ppn | input | PA_W-10 | Refill physical frame number |
| fill_size | input | 2 | Refill page size code |
| fill_asid | input | ASID_W | Refill address-space tag |
| fill_shared | input | 1 | Refill shared flag |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Single hit |
| rsp_miss | output | 1 | No way matched |
| rsp_multi | output | 1 | More than one way matched |
| rsp_idx | output | 2 | Hit way |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_lru_err | output | 1 | Miss with undecodable replacement field |
| refill_req | output | 1 | Refill request pending |
| refill_vaddr | output | VA_W | Address that missed |
| lru_state | output | 6 | Replacement field (bits 31..26) |

## Verification
The replacement logic is tested by loading all 64 field values and forcing a miss after each load. Each value must either produce exactly the expected victim, confirmed by a follow-up hit on that way, or produce the error flag. This separates a wrong decode mask from a wrong priority order.

Hits are swept at several offsets across each of four ways of different sizes, together with addresses just outside the page. This separates wrong offset masks in the match from wrong masks in the address merge.

Further cases cover the address-space rules: a shared entry, privileged single-space mode, and each of the two mode bits alone. An overlapping small page inside a large shared page produces a multiple hit. Finally, fetches are issued during a pending refill, and a register load is made in the same cycle as a hit; these check the ignore rule and the override rule.

// File: rtl/itlb4_pkg.sv
package itlb4_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int LRU_W = 6;

    typedef enum logic {
        S_LOOKUP = 1'b0,
        S_REFILL = 1'b1
    } itlb_state_e;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_e;

    // number of in-page offset bits for a size code
    function automatic int unsigned offset_bits(input logic [1:0] sz);
        case (sz)
            PG_1K:   return 10;
            PG_4K:   return 12;
            PG_64K:  return 16;
            default: return 20;
        endcase
    endfunction
endpackage

// File: rtl/itlb4_match.sv
module itlb4_match
    import itlb4_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 29,
    parameter int ASID_W   = 8,
    parameter int PG_SHIFT = 10
) (
    input  logic [WAYS-1:0]                     ent_valid,
    input  logic [WAYS-1:0]                     ent_shared,
    input  logic [WAYS-1:0][VA_W-PG_SHIFT-1:0]  ent_vpn,
    input  logic [WAYS-1:0][PA_W-PG_SHIFT-1:0]  ent_ppn,
    input  logic [WAYS-1:0][1:0]                ent_size,
    input  logic [WAYS-1:0][ASID_W-1:0]         ent_asid,
    input  logic [VA_W-1:0]                     vaddr,
    input  logic [ASID_W-1:0]                   asid,
    input  logic                                check_asid,
    output logic [WAYS-1:0]                     match_vec,
    output logic                                single_hit,
    output logic                                multi_hit,
    output logic [WAY_W-1:0]                    hit_way,
    output logic [PA_W-1:0]                     hit_paddr
);
    logic [PA_W-1:0] way_pa [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [VA_W-1:0] off_mask;
        logic [VA_W-1:0] page_base;
        logic [PA_W-1:0] frame_base;
        logic            tag_ok;

        assign off_mask   = ~({VA_W{1'b1}} << offset_bits(ent_size[g]));
        assign page_base  = {ent_vpn[g], {PG_SHIFT{1'b0}}} & ~off_mask;
        assign frame_base = {ent_ppn[g], {PG_SHIFT{1'b0}}} & ~off_mask[PA_W-1:0];
        assign tag_ok     = ent_shared[g] || !check_asid || (ent_asid[g] == asid);
        assign match_vec[g] = ent_valid[g] && tag_ok &&
                              ((vaddr & ~off_mask) == page_base);
        assign way_pa[g]  = frame_base | (vaddr[PA_W-1:0] & off_mask[PA_W-1:0]);
    end

    always_comb begin
        multi_hit  = (match_vec & (match_vec - WAYS'(1))) != '0;
        single_hit = (match_vec != '0) && !multi_hit;
        hit_way    = '0;
        hit_paddr  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match_vec[i]) begin
                hit_way   = WAY_W'(i);
                hit_paddr = hit_paddr | way_pa[i];
            end
        end
    end
endmodule

// File: rtl/itlb4_lru.sv
module itlb4_lru
    import itlb4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [LRU_W-1:0] load_val,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    output logic [LRU_W-1:0] lru_q,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_ok
);
    logic [LRU_W-1:0] lru_nx;

    // pairwise age bits: [5]=0v1 [4]=0v2 [3]=0v3 [2]=1v2 [1]=1v3 [0]=2v3
    always_comb begin
        lru_nx = lru_q;
        unique case (upd_way)
            2'd0: lru_nx[5:3] = 3'b000;
            2'd1: begin
                lru_nx[5]   = 1'b1;
                lru_nx[2:1] = 2'b00;
            end
            2'd2: begin
                lru_nx[4] = 1'b1;
                lru_nx[2] = 1'b1;
                lru_nx[0] = 1'b0;
            end
            2'd3: begin
                lru_nx[3] = 1'b1;
                lru_nx[1] = 1'b1;
                lru_nx[0] = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       lru_q <= '0;
        else if (load_en) lru_q <= load_val;
        else if (upd_en)  lru_q <= lru_nx;
    end

    always_comb begin
        victim_ok  = 1'b1;
        victim_way = 2'd0;
        if (lru_q[5] && lru_q[4] && lru_q[3])        victim_way = 2'd0;
        else if (!lru_q[5] && lru_q[2] && lru_q[1])  victim_way = 2'd1;
        else if (!lru_q[4] && !lru_q[2] && lru_q[0]) victim_way = 2'd2;
        else if (!lru_q[3] && !lru_q[1] && !lru_q[0]) victim_way = 2'd3;
        else                                          victim_ok  = 1'b0;
    end
endmodule

// File: rtl/itlb4_plru.sv
module itlb4_plru
    import itlb4_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 29,
    parameter int ASID_W   = 8,
    parameter int PG_SHIFT = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lookup_valid,
    input  logic [VA_W-1:0]          lookup_vaddr,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic                     priv_mode,
    input  logic                     single_vspace,
    input  logic                     lru_load,
    input  logic [5:0]               lru_load_val,
    input  logic                     fill_valid,
    input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
    input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
    input  logic [1:0]               fill_size,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic                     fill_shared,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     rsp_multi,
    output logic [1:0]               rsp_idx,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic                     rsp_lru_err,
    output logic                     refill_req,
    output logic [VA_W-1:0]          refill_vaddr,
    output logic [5:0]               lru_state
);
    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;

    itlb_state_e state_q, state_nx;

    logic [WAYS-1:0]              ent_valid, ent_shared;
    logic [WAYS-1:0][VPN_W-1:0]   ent_vpn;
    logic [WAYS-1:0][PPN_W-1:0]   ent_ppn;
    logic [WAYS-1:0][1:0]         ent_size;
    logic [WAYS-1:0][ASID_W-1:0]  ent_asid;

    logic [WAYS-1:0]  match_vec;
    logic             single_hit, multi_hit;
    logic [WAY_W-1:0] hit_way, victim_way, victim_q, upd_way;
    logic [PA_W-1:0]  hit_paddr;
    logic             victim_ok, check_asid, accept, no_match, upd_en, fill_take;

    assign check_asid = !(single_vspace && priv_mode);
    assign accept     = (state_q == S_LOOKUP) && lookup_valid;
    assign no_match   = !single_hit && !multi_hit;
    assign fill_take  = (state_q == S_REFILL) && fill_valid;
    assign upd_en     = (accept && single_hit) || fill_take;
    assign upd_way    = (state_q == S_REFILL) ? victim_q : hit_way;

    itlb4_match #(
        .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PG_SHIFT(PG_SHIFT)
    ) u_match (
        .ent_valid (ent_valid),
        .ent_shared(ent_shared),
        .ent_vpn   (ent_vpn),
        .ent_ppn   (ent_ppn),
        .ent_size  (ent_size),
        .ent_asid  (ent_asid),
        .vaddr     (lookup_vaddr),
        .asid      (cur_asid),
        .check_asid(check_asid),
        .match_vec (match_vec),
        .single_hit(single_hit),
        .multi_hit (multi_hit),
        .hit_way   (hit_way),
        .hit_paddr (hit_paddr)
    );

    itlb4_lru u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (lru_load),
        .load_val  (lru_load_val),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .lru_q     (lru_state),
        .victim_way(victim_way),
        .victim_ok (victim_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LOOKUP;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_LOOKUP: if (accept && no_match && victim_ok) state_nx = S_REFILL;
            S_REFILL: if (fill_valid)                      state_nx = S_LOOKUP;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_multi    <= 1'b0;
            rsp_idx      <= '0;
            rsp_paddr    <= '0;
            rsp_lru_err  <= 1'b0;
            refill_req   <= 1'b0;
            refill_vaddr <= '0;
            victim_q     <= '0;
        end else begin
            rsp_valid   <= accept;
            rsp_hit     <= accept && single_hit;
            rsp_multi   <= accept && multi_hit;
            rsp_miss    <= accept && no_match;
            rsp_lru_err <= accept && no_match && !victim_ok;
            rsp_idx     <= (accept && single_hit) ? hit_way : '0;
            rsp_paddr   <= (accept && single_hit) ? hit_paddr : '0;
            if (state_q == S_LOOKUP && state_nx == S_REFILL) begin
                refill_req   <= 1'b1;
                refill_vaddr <= lookup_vaddr;
                victim_q     <= victim_way;
            end else if (fill_take) begin
                refill_req <= 1'b0;
            end
        end
    end

    // entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_shared <= '0;
            ent_vpn    <= '0;
            ent_ppn    <= '0;
            ent_size   <= '0;
            ent_asid   <= '0;
        end else if (fill_take) begin
            ent_valid[victim_q]  <= 1'b1;
            ent_shared[victim_q] <= fill_shared;
            ent_vpn[victim_q]    <= fill_vpn;
            ent_ppn[victim_q]    <= fill_ppn;
            ent_size[victim_q]   <= fill_size;
            ent_asid[victim_q]   <= fill_asid;
        end
    end

    // R12: exactly one outcome per response
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_multi}) == 1);

    // R6: hit updates the pairwise bits of the hit way
    p_hit_way0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit && rsp_idx == 2'd0 && !$past(lru_load) |-> lru_state[5:3] == 3'b000);
    p_hit_way1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit && rsp_idx == 2'd1 && !$past(lru_load) |-> lru_state[5] && lru_state[2:1] == 2'b00);
    p_hit_way2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit && rsp_idx == 2'd2 && !$past(lru_load) |-> lru_state[4] && lru_state[2] && !lru_state[0]);
    p_hit_way3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit && rsp_idx == 2'd3 && !$past(lru_load) |-> lru_state[3] && lru_state[1] && lru_state[0]);

    // R8: request held with its address until the fill
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !fill_valid |=> refill_req && $stable(refill_vaddr));

    // R8: no responses while waiting
    p_quiet_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && $past(refill_req) |-> !rsp_valid);

    // R5: multiple hit leaves replacement state alone and asks nothing
    p_multi_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi && !$past(lru_load) |-> $stable(lru_state) && !refill_req);

    // R10: error only on a miss, never with a refill
    p_err_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_lru_err |-> rsp_miss && !refill_req);
endmodule

// File: tb/tb_itlb4_plru.sv
`timescale 1ns/1ps
module tb_itlb4_plru;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_vaddr = '0;
    logic [7:0]  cur_asid = '0;
    logic        priv_mode = 1'b0, single_vspace = 1'b0;
    logic        lru_load = 1'b0;
    logic [5:0]  lru_load_val = '0;
    logic        fill_valid = 1'b0;
    logic [21:0] fill_vpn = '0;
    logic [18:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic [7:0]  fill_asid = '0;
    logic        fill_shared = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_lru_err, refill_req;
    logic [1:0]  rsp_idx;
    logic [28:0] rsp_paddr;
    logic [31:0] refill_vaddr;
    logic [5:0]  lru_state;

    always #4 clk = ~clk;

    itlb4_plru dut (.*);

    int nchk = 0, nfail = 0;
    bit [21:0] m_vpn [4];
    bit [18:0] m_ppn [4];
    bit [1:0]  m_sz [4];
    bit [7:0]  m_asid [4];
    bit        m_v [4], m_sh [4];
    bit [5:0]  m_lru;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int obits(input bit [1:0] s);
        case (s) 2'd0: return 10; 2'd1: return 12; 2'd2: return 16; default: return 20; endcase
    endfunction

    function automatic int vic(input bit [5:0] l);
        if (l[5] && l[4] && l[3]) return 0;
        if (!l[5] && l[2] && l[1]) return 1;
        if (!l[4] && !l[2] && l[0]) return 2;
        if (!l[3] && !l[1] && !l[0]) return 3;
        return -1;
    endfunction

    function automatic bit [5:0] upd(input bit [5:0] l, input int w);
        bit [5:0] n = l;
        case (w)
            0: n[5:3] = 3'b000;
            1: begin n[5] = 1; n[2:1] = 2'b00; end
            2: begin n[4] = 1; n[2] = 1; n[0] = 0; end
            default: begin n[3] = 1; n[1] = 1; n[0] = 1; end
        endcase
        return n;
    endfunction

    function automatic bit [5:0] pick(input int w);
        case (w) 0: return 6'b111000; 1: return 6'b000110; 2: return 6'b000001; default: return 6'b000000; endcase
    endfunction

    function automatic bit [31:0] pmask(input int i);
        return (32'h1 << obits(m_sz[i])) - 1;
    endfunction

    function automatic bit mt(input int i, input bit [31:0] va, input bit [7:0] a, input bit ua);
        bit [31:0] base = ({10'b0, m_vpn[i]} << 10) & ~pmask(i);
        return m_v[i] && (m_sh[i] || !ua || m_asid[i] == a) && ((va & ~pmask(i)) == base);
    endfunction

    function automatic bit [31:0] exp_pa(input int i, input bit [31:0] va);
        return ((({13'b0, m_ppn[i]} << 10) & ~pmask(i)) | (va & pmask(i))) & 32'h1FFF_FFFF;
    endfunction

    task automatic set_fill(input bit [31:0] va, input bit [18:0] pp, input bit [1:0] sz,
                            input bit [7:0] a, input bit sh);
        fill_vpn = va[31:10]; fill_ppn = pp; fill_size = sz; fill_asid = a; fill_shared = sh;
    endtask

    task automatic set_lru(input bit [5:0] v);
        @(negedge clk); lru_load = 1; lru_load_val = v;
        @(negedge clk); lru_load = 0;
        m_lru = v;
        chk(lru_state == v, "R11 load", lru_state, v);
    endtask

    // called at a negedge with refill pending
    task automatic do_fill(input int v);
        fill_valid = 1;
        @(negedge clk); fill_valid = 0;
        m_v[v] = 1; m_vpn[v] = fill_vpn; m_ppn[v] = fill_ppn; m_sz[v] = fill_size;
        m_asid[v] = fill_asid; m_sh[v] = fill_shared;
        m_lru = upd(m_lru, v);
        chk(refill_req === 1'b0, "R9 request drop", refill_req, 0);
        chk(lru_state == m_lru, "R9 lru after fill", lru_state, m_lru);
    endtask

    task automatic lookup(input bit [31:0] va, input bit [7:0] a, input bit pr, input bit sv,
                          input string tag);
        int cnt = 0, idx = 0, v;
        bit ua = !(sv && pr);
        bit [5:0] l0 = m_lru;
        for (int i = 0; i < 4; i++) if (mt(i, va, a, ua)) begin cnt++; idx = i; end
        @(negedge clk);
        lookup_valid = 1; lookup_vaddr = va; cur_asid = a; priv_mode = pr; single_vspace = sv;
        @(negedge clk); lookup_valid = 0;
        chk(rsp_valid === 1'b1, {tag, " R12 response"}, rsp_valid, 1);
        if (cnt == 1) begin
            chk(rsp_hit === 1'b1 && rsp_idx == idx, {tag, " R2 hit way"}, {rsp_hit, rsp_idx}, {1'b1, idx[1:0]});
            chk(rsp_paddr == exp_pa(idx, va), {tag, " R4 paddr"}, rsp_paddr, exp_pa(idx, va));
            m_lru = upd(m_lru, idx);
            chk(lru_state == m_lru, {tag, " R6 lru update"}, lru_state, m_lru);
            @(negedge clk);
            chk(rsp_valid === 1'b0, {tag, " R12 single pulse"}, rsp_valid, 0);
        end else if (cnt > 1) begin
            chk(rsp_multi === 1'b1 && rsp_hit === 1'b0, {tag, " R5 multi"}, {rsp_multi, rsp_hit}, 2'b10);
            chk(lru_state == l0 && refill_req === 1'b0, {tag, " R5 no side effect"}, lru_state, l0);
        end else begin
            chk(rsp_miss === 1'b1 && rsp_hit === 1'b0, {tag, " R2 miss"}, {rsp_miss, rsp_hit}, 2'b10);
            v = vic(m_lru);
            if (v < 0) begin
                chk(rsp_lru_err === 1'b1 && refill_req === 1'b0, {tag, " R10 error"},
                    {rsp_lru_err, refill_req}, 2'b10);
            end else begin
                chk(rsp_lru_err === 1'b0, {tag, " R10 no error"}, rsp_lru_err, 0);
                chk(refill_req === 1'b1 && refill_vaddr == va, {tag, " R8 request"}, refill_vaddr, va);
                do_fill(v);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        bit [31:0] base, va;
        int sz;
        for (int i = 0; i < 4; i++) m_v[i] = 0;
        m_lru = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && refill_req === 1'b0, "R1 idle outputs", {rsp_valid, refill_req}, 0);
        chk(lru_state == 6'b0, "R1 lru reset", lru_state, 0);
        // R1 + R7: first miss naturally fills way 3
        set_fill(32'h3001_0000, 19'h00C40, 2'd2, 8'd7, 1'b0);
        lookup(32'h7000_0000, 8'd0, 0, 0, "R1 first miss");
        chk(m_v[3] == 1, "R7 reset victim", m_v[3], 1);
        // build the remaining ways at chosen slots
        set_lru(pick(0)); set_fill(32'h0040_1000, 19'h12345, 2'd1, 8'd1, 1'b0);
        lookup(32'h7000_0000, 8'd0, 0, 0, "setup0");
        set_lru(pick(1)); set_fill(32'h1000_0000, 19'h0A400, 2'd3, 8'd2, 1'b1);
        lookup(32'h7000_0000, 8'd0, 0, 0, "setup1");
        set_lru(pick(2)); set_fill(32'h2000_0400, 19'h7FFFF, 2'd0, 8'd1, 1'b0);
        lookup(32'h7000_0000, 8'd0, 0, 0, "setup2");
        // R2/R4/R6 hit sweep over every way and offsets
        for (int i = 0; i < 4; i++) begin
            sz = 1 << obits(m_sz[i]);
            base = ({10'b0, m_vpn[i]} << 10) & ~pmask(i);
            for (int k = 0; k < 8; k++)
                lookup(base + (sz / 8) * k + 4 * k, m_asid[i], 0, 0, "R2 sweep");
            lookup(base + sz - 1, m_asid[i], 0, 0, "R2 last byte");
        end
        // R3 address-space rules
        lookup(32'h1000_0ABC, 8'd9, 0, 0, "R3 shared");
        lookup(32'h0040_1010, 8'd3, 1, 1, "R3 priv single space");
        set_lru(pick(2)); set_fill(32'h7100_0000, 19'h1, 2'd0, 8'd0, 1'b0);
        lookup(32'h0040_1010, 8'd3, 0, 1, "R3 user single space");
        set_lru(pick(2)); set_fill(32'h7200_0000, 19'h2, 2'd0, 8'd0, 1'b0);
        lookup(32'h0040_1010, 8'd3, 1, 0, "R3 priv multi space");
        // R5 overlapping page
        set_lru(pick(3)); set_fill(32'h1000_2000, 19'h00777, 2'd1, 8'd2, 1'b0);
        lookup(32'h7300_0000, 8'd0, 0, 0, "R5 setup");
        lookup(32'h1000_2345, 8'd2, 0, 0, "R5 overlap");
        lookup(32'h1000_5000, 8'd2, 0, 0, "R5 outside small page");
        // R2 boundaries
        set_lru(pick(2)); set_fill(32'h7600_0000, 19'h3, 2'd0, 8'd0, 1'b0);
        lookup(32'h0040_2000, 8'd1, 0, 0, "R2 past end");
        set_lru(pick(2)); set_fill(32'h7700_0000, 19'h4, 2'd0, 8'd0, 1'b0);
        lookup(32'h0040_0FFF, 8'd1, 0, 0, "R2 before start");
        // R8: fetch ignored while waiting
        set_lru(pick(2)); set_fill(32'h7400_0000, 19'h5, 2'd0, 8'd0, 1'b0);
        @(negedge clk); lookup_valid = 1; lookup_vaddr = 32'h7500_0000; cur_asid = 0;
        priv_mode = 0; single_vspace = 0;
        @(negedge clk);
        chk(rsp_miss === 1'b1 && refill_req === 1'b1, "R8 miss enters wait", refill_req, 1);
        lookup_vaddr = 32'h0040_1010; cur_asid = 8'd1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R8 ignored fetch", rsp_valid, 0);
        chk(lru_state == m_lru && refill_req === 1'b1, "R8 wait unchanged", lru_state, m_lru);
        lookup_valid = 0;
        do_fill(2);
        // R11: load overrides a simultaneous hit update
        @(negedge clk); lookup_valid = 1; lookup_vaddr = 32'h0040_1010; cur_asid = 8'd1;
        lru_load = 1; lru_load_val = 6'b101010;
        @(negedge clk); lookup_valid = 0; lru_load = 0;
        chk(rsp_hit === 1'b1 && rsp_idx == 2'd0, "R11 hit alongside load", rsp_idx, 0);
        chk(lru_state == 6'b101010, "R11 override", lru_state, 6'b101010);
        m_lru = 6'b101010;
        // R7/R9/R10: all 64 replacement values
        for (int lv = 0; lv < 64; lv++) begin
            va = 32'h6000_0000 + (lv << 12);
            set_lru(6'(lv));
            set_fill(va, 19'(lv + 256), 2'd0, 8'd0, 1'b0);
            lookup(va, 8'd0, 0, 0, "R7 victim sweep");
            if (vic(6'(lv)) >= 0) begin
                lookup(va, 8'd0, 0, 0, "R9 placement");
                chk(m_v[vic(6'(lv))] && m_vpn[vic(6'(lv))] == va[31:10], "R9 slot", vic(6'(lv)), vic(6'(lv)));
            end
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule